// File: doc/BRIEF.md
# SPI-slave to I2S master bridge

The bridge links a microcontroller whose SPI port runs as a slave with one or two I2S audio devices. It is the clock master on both sides. From its system clock it produces one free-running serial clock, and that single clock drives the SPI shift clock and the I2S bit clock. The bridge also produces two word-select lines, one for the playback device and one for the capture device. Playback bits that the microcontroller shifts out reach the I2S data output unchanged. Bits from the I2S data input are sampled and returned to the microcontroller.

Each SPI transfer is a fixed 16-bit word, and the microcontroller sends no gaps on the clock. Because the bridge owns the clock, these transfers become a continuous stereo stream. Each frame is a left word followed by a right word. Word select changes one bit period before the first bit of the word it names. A start input gates the stream. A configuration input, read only while the link is idle, turns the capture direction on or off.

Top module: `spi_i2s_bridge`

## Requirements
- R1: While idle (after reset, or before start), `sck_o`, `ws_tx_o`, `ws_rx_o`, `sd_tx_o` and `spi_cap_o` are all low. `sd_tx_o` stays low even when `spi_play_i` is high.
- R2: If `start_i` is high at a clock edge while the link is idle, the first rising edge of `sck_o` comes on the second clock edge after that. While running, `sck_o` toggles on every clock edge (half the clock rate, 50% duty) and has no gaps between words.
- R3: Word select is low for the left word and high for the right word. It changes only at a rising edge of `sck_o`, and only at the one that opens bit 16 of a word, so it leads the next word's first bit by one bit period. The first word after start is a left word.
- R4: While running, `sd_tx_o` follows `spi_play_i` bit for bit with no reordering. Bit slot k of a word carries word bit 15-k, so the most-significant bit goes first.
- R5: At each falling edge of `sck_o`, the bridge samples `sd_rx_i` and holds it on `spi_cap_o` until the next falling edge. A slave that captures at falling edge n+1 therefore receives the bit of slot n. The first slot after start returns 0.
- R6: When `start_i` is low at the falling edge that ends the 16th bit of a right word, the link goes idle. `sck_o` and word select are low from that point, and the next start begins again with the first bit of a left word. A low `start_i` at any other point does not interrupt the stream.
- R7: `cfg_cap_en_i` is taken only while idle. When it is 0, `ws_rx_o` and `spi_cap_o` stay low for the whole run, and the playback outputs behave exactly as with capture on. A change during a run has no effect until the link is idle again.
- R8: With capture on, `ws_rx_o` has the same timing and levels as `ws_tx_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; serial clock is derived from it |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Streaming enable, checked at frame boundaries when stopping |
| cfg_cap_en_i | input | 1 | Capture direction enable, latched while idle |
| spi_play_i | input | 1 | Playback bit shifted out by the SPI slave |
| spi_cap_o | output | 1 | Captured bit returned to the SPI slave |
| sck_o | output | 1 | Shared serial clock for the SPI slave and the I2S devices |
| ws_tx_o | output | 1 | Word select for the playback device |
| sd_tx_o | output | 1 | I2S serial data to the playback device |
| ws_rx_o | output | 1 | Word select for the capture device |
| sd_rx_i | input | 1 | I2S serial data from the capture device |

## Verification
The first rising edge of `sck_o` comes two clock edges after start. Word select updates on the same edge as that rising edge. `sd_tx_o` follows the slave's bit combinationally within the same half period. The captured bit appears on `spi_cap_o` one full serial-clock period (two clock edges) after the slot it came from. The bench acts on each falling clock edge that follows a rise of `sck_o`. It drives the slave and source bits there, waits a short settle, and then compares every output with the value the requirement gives for that slot. It also counts clock edges between rises to check the serial-clock period. It checks the idle state over several cycles after each frame boundary.

// File: rtl/spi_i2s_pkg.sv
package spi_i2s_pkg;

    typedef enum logic {
        LINK_IDLE = 1'b0,
        LINK_RUN  = 1'b1
    } link_state_e;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    // Edge events: rise/fall describe the serial-clock edge produced at the next clk edge
    typedef struct packed {
        logic run;
        logic rise;
        logic fall;
    } edge_evt_t;

    // Word-select level to present for the slot now opening
    function automatic logic ws_level(input chan_e ch, input logic last_bit);
        logic lvl;
        lvl = (ch == CH_RIGHT);
        return last_bit ? ~lvl : lvl;
    endfunction

endpackage

// File: rtl/i2s_bit_timer.sv
module i2s_bit_timer
    import spi_i2s_pkg::*;
#(
    parameter int unsigned WORD_W = 16,
    localparam int unsigned CNT_W = $clog2(WORD_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output logic             sck_o,
    output edge_evt_t        evt_o,
    output logic             last_bit_o,
    output chan_e            chan_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    link_state_e      state_q;
    logic             ph_q;
    logic [CNT_W-1:0] bit_q;
    chan_e            chan_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LINK_IDLE;
            ph_q    <= 1'b0;
            bit_q   <= '0;
            chan_q  <= CH_LEFT;
        end else begin
            case (state_q)
                LINK_IDLE: begin
                    ph_q   <= 1'b0;
                    bit_q  <= '0;
                    chan_q <= CH_LEFT;
                    if (start_i) state_q <= LINK_RUN;
                end
                default: begin
                    ph_q <= ~ph_q;
                    if (ph_q) begin
                        // falling edge closes the current bit slot
                        if (bit_q == LAST) begin
                            bit_q  <= '0;
                            chan_q <= (chan_q == CH_LEFT) ? CH_RIGHT : CH_LEFT;
                            if (chan_q == CH_RIGHT && !start_i) begin
                                state_q <= LINK_IDLE;
                            end
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    always_comb begin
        evt_o.run  = (state_q == LINK_RUN);
        evt_o.rise = (state_q == LINK_RUN) && !ph_q;
        evt_o.fall = (state_q == LINK_RUN) && ph_q;
    end

    assign sck_o      = ph_q;
    assign last_bit_o = (bit_q == LAST);
    assign chan_o     = chan_q;

    // R2: continuous serial clock while running
    assert_sck_toggles_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == LINK_RUN && $past(state_q) == LINK_RUN) |-> (ph_q != $past(ph_q)));

    // R3: slot position only advances after a high phase (falling edge)
    assert_slot_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
        (bit_q != $past(bit_q)) |-> $past(ph_q));

    // R6: leaving the run state only at the end of a right word, with start low
    assert_stop_boundary_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == LINK_IDLE && $past(state_q) == LINK_RUN) |->
        ($past(chan_q) == CH_RIGHT && $past(bit_q) == LAST && !$past(start_i)));

    // R1: serial clock held low while idle
    assert_idle_sck_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == LINK_IDLE) |-> !ph_q);

endmodule

// File: rtl/i2s_play_lane.sv
module i2s_play_lane
    import spi_i2s_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  edge_evt_t evt_i,
    input  logic      last_bit_i,
    input  chan_e     chan_i,
    input  logic      play_i,
    output logic      ws_o,
    output logic      sd_o
);

    logic ws_q;

    always_ff @(posedge clk) begin
        if (rst || !evt_i.run) begin
            ws_q <= 1'b0;
        end else if (evt_i.rise) begin
            ws_q <= ws_level(chan_i, last_bit_i);
        end
    end

    assign ws_o = ws_q;
    assign sd_o = evt_i.run ? play_i : 1'b0;

    // R3: word select moves only on a serial-clock rising edge
    assert_ws_on_rise_R3: assert property (@(posedge clk) disable iff (rst)
        (ws_q != $past(ws_q)) |-> ($past(evt_i.rise) || !$past(evt_i.run)));

    // R3: word select moves only when the last bit of a word opens
    assert_ws_lead_R3: assert property (@(posedge clk) disable iff (rst)
        (ws_q != $past(ws_q) && $past(evt_i.run)) |-> $past(last_bit_i));

endmodule

// File: rtl/i2s_cap_lane.sv
module i2s_cap_lane
    import spi_i2s_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cfg_en_i,
    input  edge_evt_t evt_i,
    input  logic      last_bit_i,
    input  chan_e     chan_i,
    input  logic      sd_rx_i,
    output logic      ws_o,
    output logic      cap_o
);

    logic en_q;
    logic ws_q;
    logic cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
        end else if (!evt_i.run) begin
            en_q <= cfg_en_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !evt_i.run || !en_q) begin
            ws_q  <= 1'b0;
            cap_q <= 1'b0;
        end else begin
            if (evt_i.rise) ws_q  <= ws_level(chan_i, last_bit_i);
            if (evt_i.fall) cap_q <= sd_rx_i;
        end
    end

    assign ws_o  = ws_q;
    assign cap_o = cap_q;

    // R7: capture enable frozen during a run
    assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (evt_i.run && $past(evt_i.run)) |-> $stable(en_q));

    // R7: disabled capture keeps its outputs low
    assert_cap_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        $past(!en_q) |-> (!cap_q && !ws_q));

    // R5: captured bit changes only at a falling edge or on return to idle
    assert_cap_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
        (cap_q != $past(cap_q)) |-> ($past(evt_i.fall) || !$past(evt_i.run) || !$past(en_q)));

endmodule

// File: rtl/spi_i2s_bridge.sv
module spi_i2s_bridge
    import spi_i2s_pkg::*;
#(
    parameter int unsigned WORD_W = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic cfg_cap_en_i,
    input  logic spi_play_i,
    output logic spi_cap_o,
    output logic sck_o,
    output logic ws_tx_o,
    output logic sd_tx_o,
    output logic ws_rx_o,
    input  logic sd_rx_i
);

    edge_evt_t evt;
    logic      last_bit;
    chan_e     chan;

    i2s_bit_timer #(.WORD_W(WORD_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .sck_o      (sck_o),
        .evt_o      (evt),
        .last_bit_o (last_bit),
        .chan_o     (chan)
    );

    i2s_play_lane u_play (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (evt),
        .last_bit_i (last_bit),
        .chan_i     (chan),
        .play_i     (spi_play_i),
        .ws_o       (ws_tx_o),
        .sd_o       (sd_tx_o)
    );

    i2s_cap_lane u_cap (
        .clk        (clk),
        .rst        (rst),
        .cfg_en_i   (cfg_cap_en_i),
        .evt_i      (evt),
        .last_bit_i (last_bit),
        .chan_i     (chan),
        .sd_rx_i    (sd_rx_i),
        .ws_o       (ws_rx_o),
        .cap_o      (spi_cap_o)
    );

    // R8: capture word select never disagrees with playback word select when high
    assert_ws_pair_R8: assert property (@(posedge clk) disable iff (rst)
        ws_rx_o |-> ws_tx_o);

    // R1: no playback data leaves the bridge while the serial clock is parked
    assert_idle_data_R1: assert property (@(posedge clk) disable iff (rst)
        (!evt.run && !sck_o) |-> (!sd_tx_o && !ws_tx_o));

endmodule

// File: tb/test_spi_i2s_bridge.sv
`timescale 1ns/1ps
module test_spi_i2s_bridge;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic cfg_cap_en_i = 1'b1;
    logic spi_play_i = 1'b0;
    logic sd_rx_i = 1'b0;
    logic spi_cap_o, sck_o, ws_tx_o, sd_tx_o, ws_rx_o;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  prev_sck = 1'b0;
    logic last_rx = 1'b0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    spi_i2s_bridge i_spi_i2s_bridge (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .cfg_cap_en_i (cfg_cap_en_i),
        .spi_play_i   (spi_play_i),
        .spi_cap_o    (spi_cap_o),
        .sck_o        (sck_o),
        .ws_tx_o      (ws_tx_o),
        .sd_tx_o      (sd_tx_o),
        .ws_rx_o      (ws_rx_o),
        .sd_rx_i      (sd_rx_i)
    );

    // frames: tx left, tx right, rx left, rx right
    localparam logic [15:0] VEC [0:3][0:3] = '{
        '{16'hA5C3, 16'h3C5A, 16'h1234, 16'hFEDC},
        '{16'h8000, 16'h0001, 16'h7FFF, 16'hFFFE},
        '{16'hFFFF, 16'h0000, 16'h0000, 16'hFFFF},
        '{16'h6D29, 16'hB0E1, 16'hC001, 16'h5AA5}
    };

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic wait_rise(output int gap);
        gap = 0;
        forever begin
            bit r;
            @(negedge clk);
            gap++;
            r = sck_o && !prev_sck;
            prev_sck = sck_o;
            if (r) break;
        end
    endtask

    task automatic check_idle(input int cycles);
        spi_play_i = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            prev_sck = sck_o;
            chk("R1", "sck idle", sck_o, 1'b0);
            chk("R6", "ws_tx idle", ws_tx_o, 1'b0);
            chk("R1", "ws_rx idle", ws_rx_o, 1'b0);
            chk("R1", "sd_tx idle", sd_tx_o, 1'b0);
            chk("R1", "cap idle", spi_cap_o, 1'b0);
        end
        spi_play_i = 1'b0;
    endtask

    // one stereo frame; drop_at < 0 keeps start high, flip_at < 0 leaves cfg alone
    task automatic run_frame(input logic [15:0] tl, input logic [15:0] tr,
                             input logic [15:0] rl, input logic [15:0] rr,
                             input bit cap_on, input int drop_at, input int flip_at);
        for (int s = 0; s < 32; s++) begin
            int   gap;
            int   b;
            logic chan;
            logic tbit, rbit, ws_exp;
            b    = s % 16;
            chan = (s >= 16);
            tbit = chan ? tr[15-b] : tl[15-b];
            rbit = chan ? rr[15-b] : rl[15-b];
            ws_exp = (b == 15) ? ~chan : chan;
            wait_rise(gap);
            chk("R2", "sck period", (gap == 2), 1'b1);
            spi_play_i = tbit;
            sd_rx_i    = rbit;
            #1;
            chk("R3", "ws_tx", ws_tx_o, ws_exp);
            chk("R8", "ws_rx", ws_rx_o, cap_on ? ws_exp : 1'b0);
            chk("R4", "sd_tx", sd_tx_o, tbit);
            chk("R5", "cap", spi_cap_o, cap_on ? last_rx : 1'b0);
            last_rx = rbit;
            if (s == drop_at) start_i = 1'b0;
            if (s == flip_at) cfg_cap_en_i = ~cfg_cap_en_i;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state, start ignored while reset is held
        start_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "sck in reset", sck_o, 1'b0);
        chk("R1", "ws_tx in reset", ws_tx_o, 1'b0);
        chk("R1", "cap in reset", spi_cap_o, 1'b0);
        start_i = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        check_idle(4);

        // vector table: continuous frames, start dropped mid-way through the last
        cfg_cap_en_i = 1'b1;
        prev_sck = sck_o;
        last_rx = 1'b0;
        start_i = 1'b1;
        for (int f = 0; f < 4; f++) begin
            run_frame(VEC[f][0], VEC[f][1], VEC[f][2], VEC[f][3], 1'b1,
                      (f == 3) ? 20 : -1, -1);
        end
        // R6: frame completes, then idle on the edge that closes the right word
        @(negedge clk);
        prev_sck = sck_o;
        chk("R6", "sck after stop", sck_o, 1'b0);
        check_idle(6);

        // R7: capture off, toggle cfg mid-run, early start drop (R6)
        cfg_cap_en_i = 1'b0;
        @(negedge clk);
        prev_sck = sck_o;
        last_rx = 1'b0;
        start_i = 1'b1;
        run_frame(16'hC3A5, 16'h0F0F, 16'hFFFF, 16'hFFFF, 1'b0, 3, 5);
        @(negedge clk);
        prev_sck = sck_o;
        check_idle(4);

        // R5/R6: restart with capture on, start dropped at the very first slot
        cfg_cap_en_i = 1'b1;
        @(negedge clk);
        prev_sck = sck_o;
        last_rx = 1'b0;
        start_i = 1'b1;
        run_frame(16'h0001, 16'h8000, 16'hAAAA, 16'h5555, 1'b1, 0, -1);
        @(negedge clk);
        prev_sck = sck_o;
        check_idle(4);

        // R2: first rise exactly two clock edges after start is taken
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        chk("R2", "sck one edge after start", sck_o, 1'b0);
        start_i = 1'b0;
        @(negedge clk);
        chk("R2", "sck two edges after start", sck_o, 1'b1);
        chk("R3", "first word is left", ws_tx_o, 1'b0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule